// File: doc/BRIEF.md
# Video Clock Tap Divider and Router

This block turns a set of source clock-enable pulses into divided pixel-rate enables for four video consumers. Everything runs in one fast clock domain. Each clock is represented by a one-cycle enable pulse, so the block has no real clock-tree switching.

There are two independent paths, main and secondary. Each path works in four stages:

- It selects one of up to eight source pulse streams.
- It passes that stream through an integer divider.
- It derives fixed taps at /1, /2, /4, /6 and /12 from the divided stream.
- It gates each tap on its own.

The consumers are an interlaced encoder, a progressive encoder and an HDMI pixel stage, all fed by the main path, and a video DAC fed by the secondary path. Each consumer chooses a tap through a 4-bit code. Code 8 reaches across to the other path's /1 tap. A final per-consumer enable then gates the chosen tap.

Configuration arrives as six 32-bit register words held outside the block. The bit positions below are those the block decodes. A typical bring-up of the secondary path for a DAC runs in this order:

1. Disable the path.
2. Load the divider value and the source.
3. Enable the path and set the consumer select.
4. Release the divider reset and enable the divider.
5. Open the /1 gate.
6. Pulse the soft reset.
7. Turn on the consumer.

Top module: `vclk_router`

## Requirements
- R1: With the divider running, a path's /1 tap pulses once every M+1 selected source pulses, where M is the divider field in bits 7:0 of the path's divider word.
- R2: The divider runs only when divider-word bit 16 (enable) is 1 and bit 17 (reset) is 0. Otherwise its count returns to zero and the path emits no pulses, so after release the first /1 pulse falls on the (M+1)th source pulse.
- R3: Control-word bits 18:16 pick which `src_ce` input feeds the path. While control-word bit 19 (path enable) is 0, the path ignores its source and emits no pulses.
- R4: The /2, /4, /6 and /12 taps fire on every 2nd, 4th, 6th and 12th divided pulse, counted from a phase of zero. All taps therefore fire together on the first divided pulse after phase zero.
- R5: Control-word bits 0..4 gate the /1, /2, /4, /6 and /12 taps. A tap whose gate bit is 0 produces no pulses.
- R6: While control-word bit 15 (soft reset) is 1, the path emits no tap pulses and its tap phase is held at zero.
- R7: Consumer select codes are 0=/1, 1=/2, 2=/4, 3=/6, 4=/12 of the consumer's own path and 8=the other path's gated /1 tap. Every other code gives no pulses. The selects sit at main divider word bits 31:28 (interlaced) and 27:24 (progressive), secondary divider word bits 31:28 (DAC), and HDMI word bits 19:16 (HDMI pixel).
- R8: Consumer-gate word bits 0 (interlaced), 2 (progressive), 4 (DAC) and 5 (HDMI pixel) enable the final outputs. A consumer whose bit is 0 emits no pulses.
- R9: With the secondary divider field loaded with 54 and a source pulsing every cycle, the DAC output pulses exactly once in every 55 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ce | input | NUM_SRC | Source clock-enable pulse streams |
| main_ctl | input | 32 | Main path control: tap gates, soft reset, source, path enable |
| main_div | input | 32 | Main divider value, divider enable and reset, encoder selects |
| sec_ctl | input | 32 | Secondary path control, same layout as main_ctl |
| sec_div | input | 32 | Secondary divider value, enable and reset, DAC select |
| hdmi_ctl | input | 32 | HDMI pixel select in bits 19:16 |
| cons_gate | input | 32 | Final consumer enables |
| ilace_ce | output | 1 | Interlaced encoder clock enable |
| prog_ce | output | 1 | Progressive encoder clock enable |
| dac_ce | output | 1 | Video DAC clock enable |
| hdmi_ce | output | 1 | HDMI pixel clock enable |

## Verification
The assertions assume the divider field is changed only while that divider is disabled or held in reset. The count is compared for equality with the field, so lowering the field below a live count would make the count run past it. The stimulus respects this: every change of a divider value happens with bit 17 set, or with the path enable clear and the divider restarted afterwards. Source selects above the number of sources are never driven. Select codes 5 to 15 other than 8 are exercised only on consumers whose outputs are checked to stay idle.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
   localparam int NUM_TAPS  = 5;
   localparam int PHASE_MOD = 12;

   // control-word bit positions
   localparam int CTL_SRST   = 15;
   localparam int CTL_SRC_LO = 16;
   localparam int CTL_PEN    = 19;
   // divider-word bit positions
   localparam int DIV_ENB    = 16;
   localparam int DIV_RSTB   = 17;
   localparam int SEL_PROG   = 24;
   localparam int SEL_ILACE  = 28;
   localparam int SEL_DAC    = 28;
   localparam int SEL_HDMI   = 16;
   // consumer-gate bit positions
   localparam int CG_ILACE   = 0;
   localparam int CG_PROG    = 2;
   localparam int CG_DAC     = 4;
   localparam int CG_HDMI    = 5;

   localparam logic [3:0] CODE_OTHER = 4'd8;

   function automatic int tap_ratio(input int idx);
      case (idx)
         0:       return 1;
         1:       return 2;
         2:       return 4;
         3:       return 6;
         default: return 12;
      endcase
   endfunction
endpackage

// File: rtl/vclk_div_path.sv
module vclk_div_path
   import vclk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int NUM_SRC = 8,
   parameter int SRC_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_ce,
   input  logic                path_en,
   input  logic [SRC_W-1:0]    src_sel,
   input  logic                srst,
   input  logic                div_en,
   input  logic                div_rst,
   input  logic [DIV_W-1:0]    div_m,
   input  logic [NUM_TAPS-1:0] gate,
   output logic [NUM_TAPS-1:0] tap_raw,
   output logic [NUM_TAPS-1:0] tap_out
);
   localparam int PH_W = $clog2(PHASE_MOD);

   logic [DIV_W-1:0] cnt;
   logic [PH_W-1:0]  phase;
   logic             src_hit, running, step, div_fire;

   always_comb begin
      src_hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
         if (int'(src_sel) == i) src_hit = src_ce[i];
   end

   assign running  = div_en & ~div_rst;
   assign step     = running & path_en & src_hit;
   assign div_fire = step & (cnt == div_m);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!running) cnt <= '0;
      else if (step)     cnt <= div_fire ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase <= '0;
      else if (srst)     phase <= '0;
      else if (div_fire) phase <= (phase == PH_W'(PHASE_MOD - 1)) ? '0 : phase + 1'b1;
   end

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int RATIO = tap_ratio(i);
      assign tap_raw[i] = div_fire & ~srst & ((int'(phase) % RATIO) == 0);
   end

   assign tap_out = tap_raw & gate;
endmodule

// File: rtl/vclk_tap_sel.sv
module vclk_tap_sel
   import vclk_pkg::*;
(
   input  logic [3:0]          code,
   input  logic [NUM_TAPS-1:0] taps,
   input  logic                other_div1,
   input  logic                enable,
   output logic                ce
);
   logic hit;

   always_comb begin
      hit = 1'b0;
      if (code == CODE_OTHER) hit = other_div1;
      else if (int'(code) < NUM_TAPS) hit = taps[code[2:0]];
   end

   assign ce = enable & hit;
endmodule

// File: rtl/vclk_router.sv
module vclk_router
   import vclk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_ce,
   input  logic [31:0]        main_ctl,
   input  logic [31:0]        main_div,
   input  logic [31:0]        sec_ctl,
   input  logic [31:0]        sec_div,
   input  logic [31:0]        hdmi_ctl,
   input  logic [31:0]        cons_gate,
   output logic               ilace_ce,
   output logic               prog_ce,
   output logic               dac_ce,
   output logic               hdmi_ce
);
   localparam int SRC_W  = 3;
   localparam int N_CONS = 4;

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_divw
      $error("vclk_router: DIV_W must lie in 1..16");
   end
   if (NUM_SRC < 1 || NUM_SRC > (1 << SRC_W)) begin : g_bad_nsrc
      $error("vclk_router: NUM_SRC must lie in 1..8");
   end

   logic [NUM_TAPS-1:0] main_raw, main_tap, sec_raw, sec_tap;

   vclk_div_path #(.DIV_W(DIV_W), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_main (
      .clk(clk), .rst_n(rst_n), .src_ce(src_ce),
      .path_en(main_ctl[CTL_PEN]), .src_sel(main_ctl[CTL_SRC_LO +: SRC_W]),
      .srst(main_ctl[CTL_SRST]), .div_en(main_div[DIV_ENB]), .div_rst(main_div[DIV_RSTB]),
      .div_m(main_div[DIV_W-1:0]), .gate(main_ctl[NUM_TAPS-1:0]),
      .tap_raw(main_raw), .tap_out(main_tap));

   vclk_div_path #(.DIV_W(DIV_W), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .src_ce(src_ce),
      .path_en(sec_ctl[CTL_PEN]), .src_sel(sec_ctl[CTL_SRC_LO +: SRC_W]),
      .srst(sec_ctl[CTL_SRST]), .div_en(sec_div[DIV_ENB]), .div_rst(sec_div[DIV_RSTB]),
      .div_m(sec_div[DIV_W-1:0]), .gate(sec_ctl[NUM_TAPS-1:0]),
      .tap_raw(sec_raw), .tap_out(sec_tap));

   logic [3:0]          c_code  [N_CONS];
   logic [NUM_TAPS-1:0] c_taps  [N_CONS];
   logic                c_other [N_CONS];
   logic [N_CONS-1:0]   c_en, c_ce;

   // consumer 0: interlaced, 1: progressive, 2: DAC, 3: HDMI pixel
   assign c_code[0] = main_div[SEL_ILACE +: 4];
   assign c_code[1] = main_div[SEL_PROG  +: 4];
   assign c_code[2] = sec_div[SEL_DAC    +: 4];
   assign c_code[3] = hdmi_ctl[SEL_HDMI  +: 4];
   assign c_taps[0] = main_tap;  assign c_other[0] = sec_tap[0];
   assign c_taps[1] = main_tap;  assign c_other[1] = sec_tap[0];
   assign c_taps[2] = sec_tap;   assign c_other[2] = main_tap[0];
   assign c_taps[3] = main_tap;  assign c_other[3] = sec_tap[0];
   assign c_en = {cons_gate[CG_HDMI], cons_gate[CG_DAC], cons_gate[CG_PROG], cons_gate[CG_ILACE]};

   for (genvar c = 0; c < N_CONS; c++) begin : g_cons
      vclk_tap_sel u_sel (
         .code(c_code[c]), .taps(c_taps[c]), .other_div1(c_other[c]),
         .enable(c_en[c]), .ce(c_ce[c]));
   end

   assign ilace_ce = c_ce[0];
   assign prog_ce  = c_ce[1];
   assign dac_ce   = c_ce[2];
   assign hdmi_ce  = c_ce[3];

   logic unused_bits;
   assign unused_bits = ^{main_ctl, main_div, sec_ctl, sec_div, hdmi_ctl, cons_gate, main_raw, sec_raw};
endmodule

// File: rtl/vclk_router_chk.sv
module vclk_router_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] main_ctl,
   input logic [31:0] main_div,
   input logic [31:0] cons_gate,
   input logic [4:0]  main_raw,
   input logic [4:0]  sec_raw,
   input logic        ilace_ce,
   input logic        prog_ce
);
   logic [3:0] prog_code;
   assign prog_code = main_div[27:24];

   p_path_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !main_ctl[19] |-> (main_raw == 5'd0))
      else $error("path disabled but taps pulse");

   p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      main_div[17] |-> (main_raw == 5'd0))
      else $error("divider in reset but taps pulse");

   p_srst_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      main_ctl[15] |-> (main_raw == 5'd0))
      else $error("soft reset held but taps pulse");

   p_align_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
      main_raw[4] |-> (main_raw[3:0] == 4'hF))
      else $error("main /12 tap not aligned with lower taps");

   p_align_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_raw[4] |-> (sec_raw[3:0] == 4'hF))
      else $error("secondary /12 tap not aligned with lower taps");

   p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_code == 4'd1 && !main_ctl[1]) |-> !prog_ce)
      else $error("gated /2 tap reached consumer");

   p_bad_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_code > 4'd4 && prog_code != 4'd8) |-> !prog_ce)
      else $error("undefined select code produced pulse");

   p_cons_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cons_gate[0] |-> !ilace_ce)
      else $error("disabled consumer pulses");
endmodule

bind vclk_router vclk_router_chk u_chk (
   .clk(clk), .rst_n(rst_n), .main_ctl(main_ctl), .main_div(main_div),
   .cons_gate(cons_gate), .main_raw(main_raw), .sec_raw(sec_raw),
   .ilace_ce(ilace_ce), .prog_ce(prog_ce));

// File: tb/tb_vclk_router.sv
module tb_vclk_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_v = '0;
   logic [31:0] main_ctl = '0, main_div = '0, sec_ctl = '0, sec_div = '0;
   logic [31:0] hdmi_ctl = '0, cons_gate = '0;
   logic        ilace_ce, prog_ce, dac_ce, hdmi_ce;

   int    tests = 0, fails = 0, cyc = 0;
   int    m_dc = 0, m_tc = 0, s_dc = 0, s_tc = 0;
   int    cnt_il = 0, cnt_dac = 0;
   string cur_req = "R2";

   always #2 clk = ~clk;

   vclk_router dut (
      .clk(clk), .rst_n(rst_n), .src_ce(src_v), .main_ctl(main_ctl), .main_div(main_div),
      .sec_ctl(sec_ctl), .sec_div(sec_div), .hdmi_ctl(hdmi_ctl), .cons_gate(cons_gate),
      .ilace_ce(ilace_ce), .prog_ce(prog_ce), .dac_ce(dac_ce), .hdmi_ce(hdmi_ce));

   // ---------------- behavioural reference ----------------
   function automatic bit f_fire(logic [31:0] ctl, logic [31:0] dv, int dc);
      return dv[16] && !dv[17] && ctl[19] && src_v[ctl[18:16]] && (dc == int'(dv[7:0]));
   endfunction

   function automatic bit f_tap(bit fire, logic [31:0] ctl, int tc, int idx);
      int r;
      r = (idx == 0) ? 1 : (idx == 1) ? 2 : (idx == 2) ? 4 : (idx == 3) ? 6 : 12;
      return fire && !ctl[15] && ctl[idx] && ((tc % r) == 0);
   endfunction

   function automatic bit f_pick(logic [3:0] code, logic [31:0] ctl, bit fire, int tc,
                                 logic [31:0] octl, bit ofire, int otc);
      if (code <= 4'd4) return f_tap(fire, ctl, tc, int'(code));
      if (code == 4'd8) return f_tap(ofire, octl, otc, 0);
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      bit mf, sf, mrun, srun, mstep, sstep;
      if (!rst_n) begin
         m_dc = 0; m_tc = 0; s_dc = 0; s_tc = 0;
      end else begin
         mf = f_fire(main_ctl, main_div, m_dc);
         sf = f_fire(sec_ctl, sec_div, s_dc);
         mrun = main_div[16] && !main_div[17];
         srun = sec_div[16] && !sec_div[17];
         mstep = mrun && main_ctl[19] && src_v[main_ctl[18:16]];
         sstep = srun && sec_ctl[19] && src_v[sec_ctl[18:16]];
         if (!mrun) m_dc = 0; else if (mstep) m_dc = mf ? 0 : m_dc + 1;
         if (!srun) s_dc = 0; else if (sstep) s_dc = sf ? 0 : s_dc + 1;
         if (main_ctl[15]) m_tc = 0; else if (mf) m_tc = (m_tc + 1) % 12;
         if (sec_ctl[15])  s_tc = 0; else if (sf) s_tc = (s_tc + 1) % 12;
      end
   end

   task automatic check1(string what, bit act, bit exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0b exp=%0b cycle=%0d", cur_req, what, act, exp, cyc);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      bit mf, sf;
      #1;
      mf = rst_n && f_fire(main_ctl, main_div, m_dc);
      sf = rst_n && f_fire(sec_ctl, sec_div, s_dc);
      check1("ilace_ce", ilace_ce, cons_gate[0] && f_pick(main_div[31:28], main_ctl, mf, m_tc, sec_ctl, sf, s_tc));
      check1("prog_ce",  prog_ce,  cons_gate[2] && f_pick(main_div[27:24], main_ctl, mf, m_tc, sec_ctl, sf, s_tc));
      check1("dac_ce",   dac_ce,   cons_gate[4] && f_pick(sec_div[31:28],  sec_ctl, sf, s_tc, main_ctl, mf, m_tc));
      check1("hdmi_ce",  hdmi_ce,  cons_gate[5] && f_pick(hdmi_ctl[19:16], main_ctl, mf, m_tc, sec_ctl, sf, s_tc));
      if (ilace_ce) cnt_il++;
      if (dac_ce)   cnt_dac++;
   end

   // source patterns: input i pulses every (i+1) cycles
   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < 8; i++) src_v[i] <= ((cyc % (i + 1)) == 0);
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_count(string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s count act=%0d exp=%0d", cur_req, what, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R2: reset state, all idle
      cur_req = "R2";
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);

      // R1: main divider M=2 on source 0; interlaced /1, progressive /2, HDMI /4
      cur_req = "R1";
      main_div = 32'h0001_0002;                     // sel ilace 0, prog 0, enable, M=2
      main_div[27:24] = 4'd1;
      hdmi_ctl[19:16] = 4'd2;
      main_ctl = (32'd1 << 19) | 32'h1F;            // path on, src 0, all gates
      cons_gate = 32'h25;                           // ilace, prog, hdmi
      wait_cyc(30);
      @(negedge clk); cnt_il = 0;
      wait_cyc(300);
      check_count("ilace /1 over 300 cycles", cnt_il, 100);

      // R2: divider reset mid-run, then release
      cur_req = "R2";
      main_div[17] = 1'b1; wait_cyc(20);
      main_div[17] = 1'b0; wait_cyc(40);
      main_div[16] = 1'b0; wait_cyc(10);
      main_div[16] = 1'b1; wait_cyc(30);

      // R6/R4: soft reset realigns, then /6 and /12 taps
      cur_req = "R6";
      main_ctl[15] = 1'b1; wait_cyc(10);
      main_ctl[15] = 1'b0;
      cur_req = "R4";
      main_div[27:24] = 4'd3;
      hdmi_ctl[19:16] = 4'd4;
      main_div[31:28] = 4'd2;
      wait_cyc(150);

      // R5: gate off /6 and /4
      cur_req = "R5";
      main_ctl[3] = 1'b0; main_ctl[2] = 1'b0;
      main_div[27:24] = 4'd1; main_ctl[1] = 1'b0;
      wait_cyc(60);
      main_ctl[4:0] = 5'h1F;

      // R3: path off, then source 2 with M=1
      cur_req = "R3";
      main_ctl[19] = 1'b0; wait_cyc(40);
      main_div[17] = 1'b1;
      main_div[7:0] = 8'd1;
      main_ctl[18:16] = 3'd2;
      main_ctl[19] = 1'b1;
      main_div[17] = 1'b0;
      wait_cyc(120);

      // R9: secondary bring-up for DAC, divide by 55
      cur_req = "R9";
      sec_ctl[19] = 1'b0;
      sec_div = 32'h0002_0000;                      // divider held in reset
      sec_div[7:0] = 8'd54;
      sec_ctl[18:16] = 3'd0;
      wait_cyc(1);
      sec_ctl[19] = 1'b1;
      sec_div[31:28] = 4'd0;
      sec_div[17] = 1'b0; sec_div[16] = 1'b1;
      sec_ctl[0] = 1'b1;
      sec_ctl[15] = 1'b1; wait_cyc(1);
      sec_ctl[15] = 1'b0;
      cons_gate[4] = 1'b1;
      @(negedge clk); cnt_dac = 0;
      wait_cyc(550);
      check_count("dac over 550 cycles", cnt_dac, 10);

      // R7: cross-path code 8 and undefined codes
      cur_req = "R7";
      hdmi_ctl[19:16] = 4'd8;
      sec_div[31:28] = 4'd8;
      main_div[27:24] = 4'd5;
      wait_cyc(150);
      main_div[27:24] = 4'd15;
      main_div[31:28] = 4'd9;
      wait_cyc(60);
      sec_ctl[0] = 1'b0;                            // other path /1 gated off
      wait_cyc(120);

      // R8: consumer enables off
      cur_req = "R8";
      main_div[31:28] = 4'd0; main_div[27:24] = 4'd0;
      cons_gate = 32'h0;
      wait_cyc(40);
      cons_gate = 32'h24;
      wait_cyc(40);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule